// File: doc/BRIEF.md
# Interrupt Status and Abort Control Register

This block is the host-facing summary register of a script-driven bus controller. It gathers pending interrupt events from two places: the bus-protocol unit and the DMA/script engine. For each of these it keeps a small queue of stacked causes and shows one pending bit per source. It also holds a few host-writable control flags: an abort request to the engine, a signal-process flag and a semaphore flag. The host can also write a self-clearing software reset that sends a one-cycle reset pulse to the engine.

The register is read combinationally, so the host can poll it at any time without touching engine state. Abort is a handshake with the engine:
- The host sets the abort flag.
- The engine stops and acknowledges.
- The acknowledge is queued as an aborted DMA interrupt.
- Each further read of the DMA cause register made while the abort flag is still set queues another aborted interrupt.

To stop this, the host clears the flag before it reads DMA status. A combined interrupt line is raised whenever either pending bit is set and the global enable input is high. With the enable low, the host can still poll the register.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the register reads 0x00 (when the connected input is low), and `abort_req_o`, `sig_proc_o`, `sem_o`, `eng_srst_o`, `aborted_evt_o` and `irq_o` are all low.
- R2: The register byte is {abort[7], swreset[6], sigproc[5], sem[4], connected[3], onfly[2], bus_pend[1], dma_pend[0]}. Reading has no side effect, and the value holds steady over idle cycles.
- R3: A write loads bits 7, 5 and 4 from the write data, so writing 0x00 clears them. Write data in bits 3, 1 and 0 is ignored.
- R4: Once abort is written as 1, `abort_req_o` is high. An `abort_ack_i` pulse queues a DMA interrupt, so bit 0 sets on the next cycle, and pulses `aborted_evt_o` for one cycle.
- R5: A DMA status read (`dma_stat_rd_i`) while abort is set queues a new aborted interrupt: bit 0 stays set and `aborted_evt_o` pulses. Once abort is cleared, the same read clears bit 0.
- R6: Bus and DMA events set bits 1 and 0 independently, and both may be set at once.
- R7: Each source queues up to STACK_DEPTH (default 4) causes; extra events are dropped. A status-read strobe with no new event drops that pending bit in the next cycle. If causes remain queued, the bit re-asserts one cycle later.
- R8: A new event and a status-read strobe for the same source in the same cycle leave that pending bit set.
- R9: Writing 1 to bit 6 gives a one-cycle `eng_srst_o` pulse on the next cycle. It clears all control flags and both queues, and bit 6 always reads 0.
- R10: `irq_o` is high exactly when `gie_i` is high and bit 1 or bit 0 is set.
- R11: Bit 3 reflects `connected_i`. A `fly_evt_i` pulse sets bit 2, and only a write with bit 2 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| bus_evt_i | input | 1 | New bus-side interrupt cause |
| bus_stat_rd_i | input | 1 | Bus cause register was read (consumes one cause) |
| dma_evt_i | input | 1 | New DMA-side interrupt cause |
| dma_stat_rd_i | input | 1 | DMA status register was read (consumes one cause) |
| abort_ack_i | input | 1 | Engine has stopped on an abort request |
| connected_i | input | 1 | Bus connection status |
| fly_evt_i | input | 1 | On-the-fly interrupt event |
| gie_i | input | 1 | Global hardware interrupt enable |
| abort_req_o | output | 1 | Abort request to engine |
| sig_proc_o | output | 1 | Signal-process flag to engine |
| sem_o | output | 1 | Semaphore flag |
| eng_srst_o | output | 1 | One-cycle engine software reset |
| aborted_evt_o | output | 1 | Marks the queued DMA interrupt as aborted |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The pending logic is driven four ways:
- One event per source. This shows that the two sources set separate bits.
- Bursts of two and six events. These separate a true cause queue from a simple flag and expose where the queue saturates.
- An event and a read strobe in the same cycle. This tells the new-event-wins rule apart from the clear-wins rule.
- Abort sequences, ending with a DMA status read made with the abort flag set and again with it cleared. This distinguishes regenerated aborted interrupts from ordinary clearing.

Writes that carry ones in the read-only positions, and a reset issued while interrupts are pending, confirm which state a write can reach.

// File: rtl/irqs_pkg.sv
// Package: shared bit positions and sizes for the interrupt status register.
// Assumes an 8-bit host register; positions are fixed by the host software view.
package irqs_pkg;
    localparam int REG_W     = 8;
    localparam int NSRC      = 2;
    localparam int SRC_DMA   = 0;
    localparam int SRC_BUS   = 1;
    localparam int B_ABORT   = 7;
    localparam int B_SWRST   = 6;
    localparam int B_SIGP    = 5;
    localparam int B_SEM     = 4;
    localparam int B_CONN    = 3;
    localparam int B_ONFLY   = 2;
    localparam int B_BUSPEND = 1;
    localparam int B_DMAPEND = 0;

    typedef struct packed {
        logic abort;
        logic sigp;
        logic sem;
        logic onfly;
    } ctrl_flags_t;
endpackage

// File: rtl/irqs_stack.sv
// Module: irqs_stack
// Per-source cause queue. It counts outstanding interrupt causes up to DEPTH
// and produces a registered pending flag. A read strobe without a new event
// forces the flag low for one cycle, so the host sees a stacked cause
// re-assert. Assumes evt_i and clr_i are single-cycle strobes.
module irqs_stack #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          pend_q;
    logic          pend_d;

    // Next queue count: a new event and a read in the same cycle keep at least one cause.
    always_comb begin
        cnt_d = cnt_q;
        unique case ({evt_i, clr_i})
            2'b10: if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
            2'b01: if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
            2'b11: if (cnt_q == '0)   cnt_d = CW'(1);
            default: cnt_d = cnt_q;
        endcase
        pend_d = (cnt_d != '0) && !(clr_i && !evt_i);
    end

    // Queue and pending-flag registers with reset and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CMAX);
    p_drop_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i && !flush_i) |=> !pend_o);
    p_new_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !flush_i) |=> pend_o);
endmodule

// File: rtl/irqs_ctrl.sv
// Module: irqs_ctrl
// Host-writable control flags, abort handshake and software reset pulse.
// Assumes one write per cycle. A write carrying the reset bit overrides the
// other fields in that write. The aborted-interrupt strobe is combinational,
// so the DMA queue sees it in the same cycle as its cause.
module irqs_ctrl
    import irqs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             fly_evt_i,
    input  logic             abort_ack_i,
    input  logic             dma_rd_i,
    output ctrl_flags_t      flags_o,
    output logic             srst_req_o,
    output logic             srst_o,
    output logic             abort_evt_o,
    output logic             aborted_o
);
    ctrl_flags_t flags_q;
    logic        srst_q;
    logic        aborted_q;
    logic        srst_req;
    logic        abort_evt;

    assign srst_req  = wr_i && wdata_i[B_SWRST];
    assign abort_evt = !srst_req && (abort_ack_i || (dma_rd_i && flags_q.abort));

    // Control flag register: write loads, reset-bit write clears, on-fly event sets.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_req) begin
            flags_q <= '0;
        end else begin
            if (wr_i) begin
                flags_q.abort <= wdata_i[B_ABORT];
                flags_q.sigp  <= wdata_i[B_SIGP];
                flags_q.sem   <= wdata_i[B_SEM];
            end
            flags_q.onfly <= fly_evt_i || (flags_q.onfly && !(wr_i && wdata_i[B_ONFLY]));
        end
    end

    // One-cycle engine reset pulse and aborted-interrupt marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q    <= 1'b0;
            aborted_q <= 1'b0;
        end else begin
            srst_q    <= srst_req;
            aborted_q <= abort_evt;
        end
    end

    assign flags_o     = flags_q;
    assign srst_req_o  = srst_req;
    assign srst_o      = srst_q;
    assign abort_evt_o = abort_evt;
    assign aborted_o   = aborted_q;

    p_srst_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !srst_o);
    p_srst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (flags_o == '0));
    p_abort_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[B_ABORT] && !wdata_i[B_SWRST]) |=> flags_o.abort);
    p_regen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.abort && dma_rd_i && !srst_req) |=> aborted_o);
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: irq_status_ctrl (top)
// Host-visible interrupt status and control register. It combines the
// control flags, connection status and per-source pending bits into one
// byte, which is read combinationally with no side effect. It also drives
// the combined interrupt line. Assumes all inputs are synchronous to clk.
module irq_status_ctrl
    import irqs_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             bus_evt_i,
    input  logic             bus_stat_rd_i,
    input  logic             dma_evt_i,
    input  logic             dma_stat_rd_i,
    input  logic             abort_ack_i,
    input  logic             connected_i,
    input  logic             fly_evt_i,
    input  logic             gie_i,
    output logic             abort_req_o,
    output logic             sig_proc_o,
    output logic             sem_o,
    output logic             eng_srst_o,
    output logic             aborted_evt_o,
    output logic             irq_o
);
    ctrl_flags_t     flags;
    logic            srst_req;
    logic            abort_evt;
    logic [NSRC-1:0] src_evt;
    logic [NSRC-1:0] src_clr;
    logic [NSRC-1:0] src_pend;

    irqs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .fly_evt_i  (fly_evt_i),
        .abort_ack_i(abort_ack_i),
        .dma_rd_i   (dma_stat_rd_i),
        .flags_o    (flags),
        .srst_req_o (srst_req),
        .srst_o     (eng_srst_o),
        .abort_evt_o(abort_evt),
        .aborted_o  (aborted_evt_o)
    );

    // Route source strobes: DMA queue also takes aborted-interrupt events.
    always_comb begin
        src_evt[SRC_DMA] = dma_evt_i || abort_evt;
        src_clr[SRC_DMA] = dma_stat_rd_i;
        src_evt[SRC_BUS] = bus_evt_i;
        src_clr[SRC_BUS] = bus_stat_rd_i;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        irqs_stack #(.DEPTH(STACK_DEPTH)) u_stack (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush_i(srst_req),
            .evt_i  (src_evt[s]),
            .clr_i  (src_clr[s]),
            .pend_o (src_pend[s])
        );
    end

    // Pack the host-visible byte; the reset bit always reads as zero.
    always_comb begin
        reg_rdata_o            = '0;
        reg_rdata_o[B_ABORT]   = flags.abort;
        reg_rdata_o[B_SWRST]   = 1'b0;
        reg_rdata_o[B_SIGP]    = flags.sigp;
        reg_rdata_o[B_SEM]     = flags.sem;
        reg_rdata_o[B_CONN]    = connected_i;
        reg_rdata_o[B_ONFLY]   = flags.onfly;
        reg_rdata_o[B_BUSPEND] = src_pend[SRC_BUS];
        reg_rdata_o[B_DMAPEND] = src_pend[SRC_DMA];
    end

    assign abort_req_o = flags.abort;
    assign sig_proc_o  = flags.sigp;
    assign sem_o       = flags.sem;
    assign irq_o       = gie_i && (src_pend != '0);

    p_ro_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_wdata_i[3] || reg_wdata_i[1] || reg_wdata_i[0])
         && reg_rdata_o[1:0] == 2'b00 && !bus_evt_i && !dma_evt_i && !abort_ack_i)
        |=> (reg_rdata_o[1:0] == 2'b00));
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_i) |-> !irq_o);
    p_srst_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_srst_o |-> (src_pend == '0));
endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic bus_evt_i = 0, bus_stat_rd_i = 0, dma_evt_i = 0, dma_stat_rd_i = 0;
    logic abort_ack_i = 0, connected_i = 0, fly_evt_i = 0, gie_i = 0;
    logic abort_req_o, sig_proc_o, sem_o, eng_srst_o, aborted_evt_o, irq_o;
    int   n_checks = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    irq_status_ctrl uut (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk8(input string req, input int exp);
        check(reg_rdata_o == 8'(exp), req, reg_rdata_o, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr_i = 1; reg_wdata_i = d; tick(); reg_wr_i = 0; reg_wdata_i = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic t_reset();   // R1
        chk8("R1", 8'h00);
        check({abort_req_o, sig_proc_o, sem_o, eng_srst_o, aborted_evt_o, irq_o} == 6'b0,
              "R1", {abort_req_o, sig_proc_o, sem_o, eng_srst_o, aborted_evt_o, irq_o}, 0);
    endtask

    task automatic t_ctrl_write();   // R2 R3
        wr(8'hBB);
        chk8("R3", 8'hB0);
        check(abort_req_o && sig_proc_o && sem_o, "R3", {abort_req_o, sig_proc_o, sem_o}, 7);
        tick(); tick();
        chk8("R2", 8'hB0);
        wr(8'h00);
        chk8("R3", 8'h00);
        check(!abort_req_o, "R3", abort_req_o, 0);
    endtask

    task automatic t_conn_fly();   // R11
        connected_i = 1; #1;
        chk8("R11", 8'h08);
        connected_i = 0;
        fly_evt_i = 1; tick(); fly_evt_i = 0;
        chk8("R11", 8'h04);
        wr(8'h00);
        chk8("R11", 8'h04);
        wr(8'h04);
        chk8("R11", 8'h00);
    endtask

    task automatic t_both_sources();   // R6 R10
        bus_evt_i = 1; tick(); bus_evt_i = 0;
        chk8("R6", 8'h02);
        dma_evt_i = 1; tick(); dma_evt_i = 0;
        chk8("R6", 8'h03);
        check(!irq_o, "R10", irq_o, 0);
        gie_i = 1; #1;
        check(irq_o, "R10", irq_o, 1);
        bus_stat_rd_i = 1; tick(); bus_stat_rd_i = 0;
        chk8("R6", 8'h01);
        dma_stat_rd_i = 1; tick(); dma_stat_rd_i = 0;
        chk8("R6", 8'h00);
        check(!irq_o, "R10", irq_o, 0);
        gie_i = 0;
    endtask

    task automatic t_stack();   // R7
        bus_evt_i = 1; tick(); tick(); bus_evt_i = 0;
        bus_stat_rd_i = 1; tick(); bus_stat_rd_i = 0;
        check(reg_rdata_o[1] == 0, "R7", reg_rdata_o[1], 0);
        tick();
        check(reg_rdata_o[1] == 1, "R7", reg_rdata_o[1], 1);
        bus_stat_rd_i = 1; tick(); bus_stat_rd_i = 0; tick();
        check(reg_rdata_o[1] == 0, "R7", reg_rdata_o[1], 0);
        bus_evt_i = 1;
        for (int i = 0; i < 6; i++) tick();
        bus_evt_i = 0;
        for (int i = 0; i < 3; i++) begin
            bus_stat_rd_i = 1; tick(); bus_stat_rd_i = 0; tick();
        end
        check(reg_rdata_o[1] == 1, "R7", reg_rdata_o[1], 1);
        bus_stat_rd_i = 1; tick(); bus_stat_rd_i = 0; tick();
        check(reg_rdata_o[1] == 0, "R7", reg_rdata_o[1], 0);
    endtask

    task automatic t_same_cycle();   // R8
        dma_evt_i = 1; tick(); dma_evt_i = 0;
        dma_evt_i = 1; dma_stat_rd_i = 1; tick(); dma_evt_i = 0; dma_stat_rd_i = 0;
        check(reg_rdata_o[0] == 1, "R8", reg_rdata_o[0], 1);
        tick();
        check(reg_rdata_o[0] == 1, "R8", reg_rdata_o[0], 1);
        dma_stat_rd_i = 1; tick(); dma_stat_rd_i = 0; tick();
        check(reg_rdata_o[0] == 0, "R8", reg_rdata_o[0], 0);
    endtask

    task automatic t_abort();   // R4 R5
        wr(8'h80);
        check(abort_req_o, "R4", abort_req_o, 1);
        abort_ack_i = 1; tick(); abort_ack_i = 0;
        check(reg_rdata_o[0] && aborted_evt_o, "R4", {reg_rdata_o[0], aborted_evt_o}, 3);
        tick();
        check(!aborted_evt_o, "R4", aborted_evt_o, 0);
        dma_stat_rd_i = 1; tick(); dma_stat_rd_i = 0;
        check(reg_rdata_o[0] && aborted_evt_o, "R5", {reg_rdata_o[0], aborted_evt_o}, 3);
        tick();
        check(reg_rdata_o[0] == 1, "R5", reg_rdata_o[0], 1);
        wr(8'h00);
        dma_stat_rd_i = 1; tick(); dma_stat_rd_i = 0;
        check(!aborted_evt_o, "R5", aborted_evt_o, 0);
        tick();
        chk8("R5", 8'h00);
    endtask

    task automatic t_swreset();   // R9
        wr(8'hB0);
        bus_evt_i = 1; dma_evt_i = 1; tick(); bus_evt_i = 0; dma_evt_i = 0;
        chk8("R9", 8'hB3);
        check(!eng_srst_o, "R9", eng_srst_o, 0);
        wr(8'h40);
        check(eng_srst_o, "R9", eng_srst_o, 1);
        chk8("R9", 8'h00);
        tick();
        check(!eng_srst_o, "R9", eng_srst_o, 0);
        chk8("R9", 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_ctrl_write();
        t_conn_fly();
        t_both_sources();
        t_stack();
        t_same_cycle();
        t_abort();
        t_swreset();
        finish_run();
    end
endmodule